// File: doc/BRIEF.md
# Flash Page Erase and Program Sequencer

This block is a register-mapped controller that guards page erase and page program operations on an on-chip flash array. Software first writes an unlock pair into two key registers. The order of the two key values, 0x55 and 0xAA, decides whether an erase or a program is armed. Once armed, an ordinary write to any location of the flash array starts the operation on the page that holds that location. An erase fills the page with 0xFF. A program copies one page from a RAM buffer into the page. The RAM buffer's address is held in a register.

The operation engine moves one byte per clock. It uses a synchronous RAM read port, whose data arrives one cycle after the address, and a flash byte write port. When the engine finishes, a sticky done flag is raised and drives the interrupt line. A wrong unlock value raises a sticky error flag and drops the sequencer back to idle. Both flags are cleared by writing ones to them. While the engine runs, key writes and array-write triggers are ignored.

Top module: `flash_page_seq`

## Requirements
- R1: After reset the control register, both key registers and the status register read 0, the buffer-address register reads its reset parameter (default 0xC3E00), and `irq` and `busy` are low.
- R2: Writing 0x55 to key register A (byte offset 0x04) and then 0xAA to key register B (offset 0x08) arms an erase. The next array write sets every byte of the page holding the written address to 0xFF. The page base is the address with its page-offset bits cleared.
- R3: Writing 0xAA to key A and then 0x55 to key B arms a program. The next array write copies one page into the target page, byte i of the page receiving RAM byte (buffer[23:0] − RAM base + i), with the RAM offset taken modulo the RAM size.
- R4: Writing any value other than 0x55 or 0xAA to key A sets status bit 1 (error) and returns the sequencer to idle.
- R5: A key B write that does not complete a valid pair sets status bit 1 and returns the sequencer to idle. This covers key B without a prior key A, 0x55 then 0x55, and 0xAA then 0xAA.
- R6: The page size is 512 bytes when control bits [31:3] are all zero and 256 bytes otherwise.
- R7: When an operation completes, status bit 0 (done) is set, `busy` falls in the same cycle, and `irq` equals status bit 0 at all times.
- R8: A write to the status register (offset 0x0C) clears each of bits [1:0] that is written as 1 and leaves the others unchanged.
- R9: An array write while no operation is armed changes no flash byte and no status bit.
- R10: While `busy` is high, key writes and array writes are ignored. They set no error and start no operation.
- R11: An operation writes one flash byte per clock at consecutive addresses. `busy` stays high for page size + 1 cycles after the triggering edge.
- R12: The control, key and buffer-address registers read back the last value accepted. The status register reads its two flag bits in [1:0] and zero above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| arr_we | input | 1 | CPU write strobe into the flash array |
| arr_addr | input | FLASH_AW | Flash array byte address of that write |
| fl_we | output | 1 | Flash storage byte write enable |
| fl_addr | output | FLASH_AW | Flash storage byte address |
| fl_wdata | output | 8 | Flash storage byte data |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_rdata | input | 8 | RAM read data, valid one cycle after ram_re |
| busy | output | 1 | Erase or program in progress |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with a 4 KiB flash array (FLASH_AW=12), a 1 KiB RAM (RAM_AW=10) and a buffer reset value of 0xC0200. At these sizes the bench can keep full byte models of both memories and compare the entire array after every operation. That comparison shows that bytes just below and above the affected page stay untouched. The small RAM also makes the offset truncation of the buffer address visible. The sizes keep 512-byte and 256-byte pages at several page bases within reach in a short run.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned PG_LG_BIG   = 9;
  localparam int unsigned PG_LG_SMALL = 8;
  localparam int unsigned IDX_W       = PG_LG_BIG;

  localparam logic [31:0] KEY_LO = 32'h0000_0055;
  localparam logic [31:0] KEY_HI = 32'h0000_00AA;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_KEYA = 3'd1,
    REG_KEYB = 3'd2,
    REG_STAT = 3'd3,
    REG_BUF  = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_GOT_LO,
    KS_GOT_HI,
    KS_ARM_ERASE,
    KS_ARM_PROG
  } key_state_e;

endpackage

// File: rtl/fseq_unlock.sv
module fseq_unlock
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        keya_we,
  input  logic        keyb_we,
  input  logic [31:0] wdata,
  input  logic        fire,
  output logic        arm_erase,
  output logic        arm_prog,
  output logic        key_err
);

  key_state_e st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d    = st_q;
    key_err = 1'b0;
    if (keya_we) begin
      if (wdata == KEY_LO)      st_d = KS_GOT_LO;
      else if (wdata == KEY_HI) st_d = KS_GOT_HI;
      else begin
        st_d    = KS_IDLE;
        key_err = 1'b1;
      end
    end else if (keyb_we) begin
      if (st_q == KS_GOT_LO && wdata == KEY_HI)      st_d = KS_ARM_ERASE;
      else if (st_q == KS_GOT_HI && wdata == KEY_LO) st_d = KS_ARM_PROG;
      else begin
        st_d    = KS_IDLE;
        key_err = 1'b1;
      end
    end else if (fire) begin
      st_d = KS_IDLE;
    end
  end

  assign st_en = keya_we | keyb_we | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= KS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign arm_erase = (st_q == KS_ARM_ERASE);
  assign arm_prog  = (st_q == KS_ARM_PROG);

endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
  import flash_seq_pkg::*;
#(
  parameter int unsigned FLASH_AW = 19,
  parameter int unsigned RAM_AW   = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode_prog,
  input  logic                page_small,
  input  logic [FLASH_AW-1:0] trig_addr,
  input  logic [RAM_AW-1:0]   src_off,
  input  logic [7:0]          ram_rdata,
  output logic                busy,
  output logic                done,
  output logic                fl_we,
  output logic [FLASH_AW-1:0] fl_addr,
  output logic [7:0]          fl_wdata,
  output logic                ram_re,
  output logic [RAM_AW-1:0]   ram_addr
);

  localparam logic [IDX_W-1:0] LAST_BIG   = IDX_W'((1 << PG_LG_BIG) - 1);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'((1 << PG_LG_SMALL) - 1);

  // issue stage
  logic                run_q, run_d;
  logic                mode_q, mode_d;
  logic [FLASH_AW-1:0] base_q, base_d;
  logic [RAM_AW-1:0]   src_q, src_d;
  logic [IDX_W-1:0]    last_q, last_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  // write stage
  logic                pv_q, pv_d;
  logic                plast_q, plast_d;
  logic [IDX_W-1:0]    pidx_q, pidx_d;

  logic                issue_end;
  logic                load;
  logic [FLASH_AW-1:0] off_mask;

  assign busy      = run_q | pv_q;
  assign load      = start & ~busy;
  assign issue_end = run_q & (idx_q == last_q);
  assign off_mask  = FLASH_AW'(page_small ? LAST_SMALL : LAST_BIG);

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    base_d = base_q;
    src_d  = src_q;
    last_d = last_q;
    idx_d  = idx_q;
    if (load) begin
      run_d  = 1'b1;
      mode_d = mode_prog;
      base_d = trig_addr & ~off_mask;
      src_d  = src_off;
      last_d = page_small ? LAST_SMALL : LAST_BIG;
      idx_d  = '0;
    end else if (run_q) begin
      idx_d = idx_q + 1'b1;
      if (issue_end) run_d = 1'b0;
    end
    pv_d    = run_q;
    pidx_d  = idx_q;
    plast_d = issue_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      base_q <= '0;
      src_q  <= '0;
      last_q <= '0;
      idx_q  <= '0;
    end else if (load | run_q) begin
      run_q  <= run_d;
      mode_q <= mode_d;
      base_q <= base_d;
      src_q  <= src_d;
      last_q <= last_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q    <= 1'b0;
      plast_q <= 1'b0;
      pidx_q  <= '0;
    end else if (run_q | pv_q) begin
      pv_q    <= pv_d;
      plast_q <= plast_d;
      pidx_q  <= pidx_d;
    end
  end

  generate
    if (RAM_AW > IDX_W) begin : g_wide_ram
      assign ram_addr = src_q + RAM_AW'(idx_q);
    end else begin : g_narrow_ram
      assign ram_addr = src_q + idx_q[RAM_AW-1:0];
    end
  endgenerate

  assign ram_re   = run_q & mode_q;
  assign fl_we    = pv_q;
  assign fl_addr  = base_q + FLASH_AW'(pidx_q);
  assign fl_wdata = mode_q ? ram_rdata : 8'hFF;
  assign done     = pv_q & plast_q;

endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned FLASH_AW  = 19,
  parameter int unsigned RAM_AW    = 14,
  parameter logic [23:0] RAM_BASE  = 24'h0C_0000,
  parameter logic [31:0] BUF_RESET = 32'h000C_3E00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [4:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                arr_we,
  input  logic [FLASH_AW-1:0] arr_addr,
  output logic                fl_we,
  output logic [FLASH_AW-1:0] fl_addr,
  output logic [7:0]          fl_wdata,
  output logic                ram_re,
  output logic [RAM_AW-1:0]   ram_addr,
  input  logic [7:0]          ram_rdata,
  output logic                busy,
  output logic                irq
);

  logic [31:0] ctrl_q, keya_q, keyb_q, buf_q;
  logic [1:0]  stat_q, stat_d;
  logic        aligned;
  reg_sel_e    sel;
  logic        ctrl_en, keya_en, keyb_en, stat_en, buf_en;
  logic        arm_erase, arm_prog, key_err;
  logic        fire, op_done;
  logic [23:0] src_full;
  logic [1:0]  clr_mask;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(reg_addr[4:2]);

  assign ctrl_en = reg_we & aligned & (sel == REG_CTRL);
  assign keya_en = reg_we & aligned & (sel == REG_KEYA) & ~busy;
  assign keyb_en = reg_we & aligned & (sel == REG_KEYB) & ~busy;
  assign stat_en = reg_we & aligned & (sel == REG_STAT);
  assign buf_en  = reg_we & aligned & (sel == REG_BUF);

  assign fire = arr_we & (arm_erase | arm_prog) & ~busy;

  fseq_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .keya_we   (keya_en),
    .keyb_we   (keyb_en),
    .wdata     (reg_wdata),
    .fire      (fire),
    .arm_erase (arm_erase),
    .arm_prog  (arm_prog),
    .key_err   (key_err)
  );

  assign src_full = buf_q[23:0] - RAM_BASE;

  fseq_engine #(
    .FLASH_AW (FLASH_AW),
    .RAM_AW   (RAM_AW)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fire),
    .mode_prog  (arm_prog),
    .page_small (|ctrl_q[31:3]),
    .trig_addr  (arr_addr),
    .src_off    (src_full[RAM_AW-1:0]),
    .ram_rdata  (ram_rdata),
    .busy       (busy),
    .done       (op_done),
    .fl_we      (fl_we),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr)
  );

  // status flags: sticky set wins over a same-cycle clear
  always_comb begin
    clr_mask = stat_en ? reg_wdata[1:0] : 2'b00;
    stat_d   = (stat_q & ~clr_mask) | {key_err, op_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 2'b00;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keya_q <= '0;
    else if (keya_en) keya_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keyb_q <= '0;
    else if (keyb_en) keyb_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= BUF_RESET;
    else if (buf_en) buf_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      unique case (sel)
        REG_CTRL: reg_rdata = ctrl_q;
        REG_KEYA: reg_rdata = keya_q;
        REG_KEYB: reg_rdata = keyb_q;
        REG_STAT: reg_rdata = {30'd0, stat_q};
        REG_BUF:  reg_rdata = buf_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign irq = stat_q[0];

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int unsigned FLASH_AW = 19
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                irq,
  input logic                fl_we,
  input logic [FLASH_AW-1:0] fl_addr,
  input logic                ram_re,
  input logic                reg_we,
  input logic [1:0]          stat_q
);

  assert_irq_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_irq_rise_only_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  assert_flash_write_inside_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> busy);

  assert_ram_read_inside_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> busy);

  assert_consecutive_bytes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && $past(fl_we)) |-> (fl_addr == FLASH_AW'($past(fl_addr) + 1'b1)));

  assert_no_err_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> !$rose(stat_q[1]));

endmodule

bind flash_page_seq fseq_checker #(.FLASH_AW(FLASH_AW)) u_fseq_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .irq     (irq),
  .fl_we   (fl_we),
  .fl_addr (fl_addr),
  .ram_re  (ram_re),
  .reg_we  (reg_we),
  .stat_q  (stat_q)
);

// File: tb/flash_page_seq_test.sv
module flash_page_seq_test;

  localparam int unsigned FAW   = 12;
  localparam int unsigned RAW   = 10;
  localparam int unsigned FSIZE = 1 << FAW;
  localparam int unsigned RSIZE = 1 << RAW;
  localparam logic [31:0] BUFRST = 32'h000C_0200;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_KEYA = 5'h04;
  localparam logic [4:0] A_KEYB = 5'h08;
  localparam logic [4:0] A_STAT = 5'h0C;
  localparam logic [4:0] A_BUF  = 5'h10;

  // fields: keyA, keyB, array address, ctrl, buffer, op (0 none, 1 erase, 2 program)
  typedef struct packed {
    logic [7:0]  ka;
    logic [7:0]  kb;
    logic [11:0] addr;
    logic [31:0] ctrl;
    logic [31:0] bufa;
    logic [1:0]  op;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h55, 8'hAA, 12'h234, 32'h0, 32'h000C_0200, 2'd1},
    '{8'hAA, 8'h55, 12'hA10, 32'h0, 32'h000C_0200, 2'd2},
    '{8'h55, 8'hAA, 12'h5C3, 32'h8, 32'h000C_0200, 2'd1},
    '{8'hAA, 8'h55, 12'h7F0, 32'h8, 32'h000C_0080, 2'd2},
    '{8'h55, 8'h55, 12'h100, 32'h0, 32'h000C_0200, 2'd0},
    '{8'hAA, 8'hAA, 12'h300, 32'h0, 32'h000C_0200, 2'd0},
    '{8'h12, 8'hAA, 12'hC00, 32'h0, 32'h000C_0200, 2'd0},
    '{8'h55, 8'h00, 12'hD00, 32'h0, 32'h000C_0200, 2'd0}
  };

  logic           clk;
  logic           rst_n;
  logic           reg_we;
  logic [4:0]     reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;
  logic           arr_we;
  logic [FAW-1:0] arr_addr;
  logic           fl_we;
  logic [FAW-1:0] fl_addr;
  logic [7:0]     fl_wdata;
  logic           ram_re;
  logic [RAW-1:0] ram_addr;
  logic [7:0]     ram_rdata;
  logic           busy;
  logic           irq;

  logic [7:0] fl_mem  [FSIZE];
  logic [7:0] exp_fl  [FSIZE];
  logic [7:0] ram_mem [RSIZE];

  int checks;
  int errors;

  flash_page_seq #(
    .FLASH_AW  (FAW),
    .RAM_AW    (RAW),
    .RAM_BASE  (24'h0C_0000),
    .BUF_RESET (BUFRST)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .fl_we     (fl_we),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory models
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= ram_mem[ram_addr];
    if (fl_we)  fl_mem[fl_addr] <= fl_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic arr_write(input logic [FAW-1:0] a);
    @(negedge clk);
    arr_we = 1'b1; arr_addr = a;
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  // call right after arr_write: counts busy cycles at falling edges
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_flash(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < FSIZE; i++) if (fl_mem[i] !== exp_fl[i]) bad++;
    check(req, bad, 0);
  endtask

  task automatic model_op(input logic [1:0] op, input logic [FAW-1:0] a,
                          input logic [31:0] ctl, input logic [31:0] bf);
    int psz;
    int base;
    int src;
    psz  = (ctl[31:3] != 0) ? 256 : 512;
    base = int'(a) & ~(psz - 1);
    src  = int'(bf[23:0]) - 32'h0C_0000;
    for (int i = 0; i < psz; i++) begin
      if (op == 2'd1) exp_fl[base + i] = 8'hFF;
      else if (op == 2'd2) exp_fl[base + i] = ram_mem[(src + i) % RSIZE];
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int n;
    checks = 0; errors = 0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    arr_we = 1'b0; arr_addr = '0; ram_rdata = '0;
    for (int i = 0; i < FSIZE; i++) begin
      fl_mem[i] = 8'(i ^ (i >> 4) ^ 8'h5A);
      exp_fl[i] = fl_mem[i];
    end
    for (int i = 0; i < RSIZE; i++) ram_mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(A_CTRL, rd); check("R1 ctrl", rd, 0);
    rd_reg(A_KEYA, rd); check("R1 keyA", rd, 0);
    rd_reg(A_STAT, rd); check("R1 status", rd, 0);
    rd_reg(A_BUF, rd);  check("R1 buffer", rd, BUFRST);
    check("R1 irq/busy", {30'd0, irq, busy}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int v = 0; v < NV; v++) begin
      wr_reg(A_CTRL, VECS[v].ctrl);
      wr_reg(A_BUF, VECS[v].bufa);
      wr_reg(A_STAT, 32'h3);
      wr_reg(A_KEYA, {24'd0, VECS[v].ka});
      wr_reg(A_KEYB, {24'd0, VECS[v].kb});
      arr_write(VECS[v].addr);
      wait_idle(n);
      model_op(VECS[v].op, VECS[v].addr, VECS[v].ctrl, VECS[v].bufa);
      if (VECS[v].op != 0) begin
        check("R11 busy length", n, ((VECS[v].ctrl[31:3] != 0) ? 256 : 512) + 1);
        rd_reg(A_STAT, rd); check("R7 done flag", rd, 32'h1);
        check("R7 irq", {31'd0, irq}, 1);
        cmp_flash(VECS[v].op == 1 ? "R2/R6 erase page" : "R3/R6 program page");
      end else begin
        check("R9 no op started", n, 0);
        rd_reg(A_STAT, rd); check(VECS[v].ka == 8'h12 ? "R4 bad keyA" : "R5 bad pair", rd, 32'h2);
        check("R7 irq low", {31'd0, irq}, 0);
        cmp_flash("R5 flash unchanged");
      end
    end

    // R5 key B without key A
    wr_reg(A_STAT, 32'h3);
    wr_reg(A_KEYB, 32'hAA);
    rd_reg(A_STAT, rd); check("R5 keyB alone", rd, 32'h2);

    // R9 array write when idle
    wr_reg(A_STAT, 32'h3);
    arr_write(12'h040);
    repeat (3) @(negedge clk);
    check("R9 busy stays low", {31'd0, busy}, 0);
    rd_reg(A_STAT, rd); check("R9 status unchanged", rd, 0);
    cmp_flash("R9 flash unchanged");

    // R10: triggers and keys during an operation
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_KEYA, 32'h55);
    wr_reg(A_KEYB, 32'hAA);
    arr_write(12'hE10);
    wr_reg(A_KEYA, 32'h33);
    arr_write(12'h010);
    rd_reg(A_KEYA, rd); check("R10 keyA write dropped", rd, 32'h55);
    wait_idle(n);
    model_op(2'd1, 12'hE10, 32'h0, 32'h0);
    rd_reg(A_STAT, rd); check("R10 no error while busy", rd, 32'h1);
    cmp_flash("R10 second trigger ignored");
    arr_write(12'h010);
    repeat (2) @(negedge clk);
    cmp_flash("R10 sequencer idle after op");

    // R8 partial write-1-to-clear
    wr_reg(A_KEYA, 32'h77);
    rd_reg(A_STAT, rd); check("R8 both flags", rd, 32'h3);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, rd); check("R8 clear bit0 only", rd, 32'h2);
    check("R7 irq follows bit0", {31'd0, irq}, 0);
    wr_reg(A_STAT, 32'h2);
    rd_reg(A_STAT, rd); check("R8 clear bit1", rd, 32'h0);

    // R12 readback
    wr_reg(A_CTRL, 32'hDEAD_BEE8);
    rd_reg(A_CTRL, rd); check("R12 ctrl readback", rd, 32'hDEAD_BEE8);
    wr_reg(A_BUF, 32'h1234_5678);
    rd_reg(A_BUF, rd); check("R12 buffer readback", rd, 32'h1234_5678);
    wr_reg(A_STAT, 32'hFFFF_FFFC);
    rd_reg(A_STAT, rd); check("R12 status upper zero", rd, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule